// File: doc/BRIEF.md
# Two-Channel Time-Difference Histogrammer

The block measures how far apart in time two logic signals rise and builds a histogram of those gaps in on-chip memory. Two 6-bit source codes pick channel A and channel B from a shared 64-entry signal space. That space holds the trigger inputs, the sync-related lines, the debug lines, the auxiliary inputs, the AND and OR results and the multiplicity results. Each selected line passes through a synchronizer and a rising-edge detector. A free-running counter stamps each edge.

Each pairing of an A edge with a B edge gives a signed gap, A time minus B time. A gap within ±511 clocks adds one to its bin in a 1024-bin table. Each bin is a saturating counter.

Software sets the two source codes and reads them back through a small write port. A clear command zeroes every bin, and software issues one after every change of source. A readout command streams all bins out in ascending order, one per clock. While a clear or a readout runs, `busy` is high and edge pairs are not counted.

Top module: `tdiff_histo`

## Requirements
- R1: Source code mapping: 0–23 pick `trig_in[code]`; 24–27 pick `sync_in[code-24]`; 28–31 pick `dbg_in[code-28]`; 32–35 pick `aux_in[code-32]`; 40–41 pick `and_in[code-40]`; 48–55 pick `mult_in[code-48]`; 56–63 pick `or_in[code-56]`. Every other code selects a constant low line, which never makes an edge.
- R2: The gap is tA − tB in clocks; positive means A rose later. A rising edge of A pairs with the latest B edge. A rising edge of B pairs with an A edge still waiting unpaired, which gives a negative gap. A pair adds one to bin (gap + 512), and repeated pairs accumulate.
- R3: Only gaps from −511 to +511 inclusive are counted. A gap of magnitude 512 or more changes no bin.
- R4: When A and B rise in the same cycle, bin 512 gets exactly one count.
- R5: A one-cycle `clr_req` pulse while idle sets every bin to zero. `busy` is high for exactly 1024 consecutive cycles, starting at the clock edge that samples the request.
- R6: A one-cycle `rd_req` pulse while idle makes `rd_valid` high for 1024 consecutive cycles. During those cycles `rd_bin` steps 0,1,…,1023 and `rd_count` carries that bin's contents. `rd_valid` is only high in the cycle after a cycle with `busy` high.
- R7: Pairs that complete while `busy` is high leave the histogram unchanged.
- R8: A bin that holds the all-ones value keeps it when further pairs land in it.
- R9: With `cfg_we` high, `cfg_code` is stored as the A source if `cfg_ch`=0 and as the B source if `cfg_ch`=1. The stored codes appear on `src_a`/`src_b` and change only on such a write.
- R10: After reset, `busy` and `rd_valid` are low and both source codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 24 | Trigger lines (codes 0–23) |
| sync_in | input | 4 | Sync-related lines (codes 24–27) |
| dbg_in | input | 4 | Debug lines (codes 28–31) |
| aux_in | input | 4 | Auxiliary inputs (codes 32–35) |
| and_in | input | 2 | AND results (codes 40–41) |
| mult_in | input | 8 | Multiplicity results (codes 48–55) |
| or_in | input | 8 | OR results (codes 56–63) |
| cfg_we | input | 1 | Source code write strobe |
| cfg_ch | input | 1 | Write target: 0 = A, 1 = B |
| cfg_code | input | 6 | Source code to store |
| src_a | output | 6 | Stored A source code |
| src_b | output | 6 | Stored B source code |
| clr_req | input | 1 | Start clear sweep |
| rd_req | input | 1 | Start readout sweep |
| busy | output | 1 | Clear or readout in progress |
| rd_valid | output | 1 | Readout data valid |
| rd_bin | output | BIN_AW | Bin index being read out |
| rd_count | output | CNT_W | Contents of that bin |

## Verification
The assertions assume that `clr_req` and `rd_req` come as single-cycle pulses. They also assume the control port is the only path that changes the source codes. On that basis they check the sweep length, the bin order and the code stability at the ports. The stimulus gives every edge pair two-cycle pulses. It spaces unrelated pairs more than 511 clocks apart, or separates them with a full clear, so that each expected bin depends only on the pair under test. It raises requests only while the block is idle, apart from the deliberate edge pairs fired into a running sweep.

// File: rtl/tdiff_histo.sv
module tdiff_histo #(
  parameter int BIN_AW = 10,
  parameter int CNT_W  = 32,
  parameter int TS_W   = 12,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [23:0]       trig_in,
  input  logic [3:0]        sync_in,
  input  logic [3:0]        dbg_in,
  input  logic [3:0]        aux_in,
  input  logic [1:0]        and_in,
  input  logic [7:0]        mult_in,
  input  logic [7:0]        or_in,
  input  logic              cfg_we,
  input  logic              cfg_ch,
  input  logic [5:0]        cfg_code,
  output logic [5:0]        src_a,
  output logic [5:0]        src_b,
  input  logic              clr_req,
  input  logic              rd_req,
  output logic              busy,
  output logic              rd_valid,
  output logic [BIN_AW-1:0] rd_bin,
  output logic [CNT_W-1:0]  rd_count
);
  // TS_W must exceed BIN_AW so that an expired pairing is seen before the stamp wraps
  localparam int NBINS = 1 << BIN_AW;
  localparam logic [BIN_AW-1:0] CENTER = BIN_AW'(NBINS / 2);
  localparam logic [TS_W-1:0]   WIN    = TS_W'(NBINS / 2 - 1);

  typedef enum logic [1:0] {M_IDLE, M_CLR, M_RD} mode_t;

  function automatic logic pick(input logic [5:0] c, input logic [53:0] b);
    if (c < 6'd36)                     return b[c];
    else if (c == 6'd40 || c == 6'd41) return b[c - 6'd4];
    else if (c >= 6'd48)               return b[c - 6'd10];
    else                               return 1'b0;
  endfunction

  logic [53:0] sig_bus;
  logic [5:0]  src_a_q, src_b_q;
  logic [SYNC_N-1:0] sh_a, sh_b;
  logic        prev_a, prev_b, edge_a, edge_b;
  logic [TS_W-1:0] ts, t_a, t_b, el_a, el_b;
  logic        a_ok, b_ok, a_hit, b_hit;
  logic        ev_now, ev_v;
  logic [BIN_AW-1:0] ev_bin_now, ev_bin;
  mode_t       mode;
  logic [BIN_AW-1:0] ptr;
  logic [CNT_W-1:0]  mem [NBINS];
  logic [CNT_W-1:0]  cur;

  assign sig_bus = {or_in, mult_in, and_in, aux_in, dbg_in, sync_in, trig_in};
  assign src_a   = src_a_q;
  assign src_b   = src_b_q;
  assign busy    = (mode != M_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_a_q <= '0;
      src_b_q <= '0;
    end else if (cfg_we) begin
      if (cfg_ch) src_b_q <= cfg_code;
      else        src_a_q <= cfg_code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_a <= '0; sh_b <= '0; prev_a <= 1'b0; prev_b <= 1'b0;
    end else begin
      sh_a   <= {sh_a[SYNC_N-2:0], pick(src_a_q, sig_bus)};
      sh_b   <= {sh_b[SYNC_N-2:0], pick(src_b_q, sig_bus)};
      prev_a <= sh_a[SYNC_N-1];
      prev_b <= sh_b[SYNC_N-1];
    end
  end

  assign edge_a = sh_a[SYNC_N-1] & ~prev_a;
  assign edge_b = sh_b[SYNC_N-1] & ~prev_b;
  assign el_a   = ts - t_a;
  assign el_b   = ts - t_b;
  assign a_hit  = a_ok && (el_a <= WIN);
  assign b_hit  = b_ok && (el_b <= WIN);

  always_comb begin
    ev_now     = 1'b0;
    ev_bin_now = CENTER;
    if (edge_a) begin
      if (edge_b) begin
        ev_now = 1'b1;
      end else if (b_hit) begin
        ev_now     = 1'b1;
        ev_bin_now = CENTER + el_b[BIN_AW-1:0];
      end
    end else if (edge_b && a_hit) begin
      ev_now     = 1'b1;
      ev_bin_now = CENTER - el_a[BIN_AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts <= '0; t_a <= '0; t_b <= '0; a_ok <= 1'b0; b_ok <= 1'b0;
    end else begin
      ts <= ts + 1'b1;
      if (edge_b) begin
        t_b  <= ts;
        b_ok <= 1'b1;
      end else if (!b_hit) begin
        b_ok <= 1'b0;
      end
      if (edge_a) begin
        if (edge_b || b_hit) begin
          a_ok <= 1'b0;
        end else begin
          t_a  <= ts;
          a_ok <= 1'b1;
        end
      end else if ((edge_b && a_hit) || !a_hit) begin
        a_ok <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_v   <= 1'b0;
      ev_bin <= '0;
    end else begin
      ev_v   <= ev_now && (mode == M_IDLE) && !clr_req && !rd_req;
      ev_bin <= ev_bin_now;
    end
  end

  assign cur = mem[ev_bin];

  always_ff @(posedge clk) begin
    if (mode == M_CLR)
      mem[ptr] <= '0;
    else if (mode == M_IDLE && ev_v)
      mem[ev_bin] <= (&cur) ? cur : cur + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_IDLE;
      ptr  <= '0;
    end else begin
      case (mode)
        M_IDLE: begin
          ptr <= '0;
          if (clr_req)     mode <= M_CLR;
          else if (rd_req) mode <= M_RD;
        end
        default: begin
          ptr <= ptr + 1'b1;
          if (&ptr) mode <= M_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_bin   <= '0;
      rd_count <= '0;
    end else begin
      rd_valid <= (mode == M_RD);
      rd_bin   <= ptr;
      rd_count <= mem[ptr];
    end
  end
endmodule

// File: rtl/tdiff_histo_chk.sv
module tdiff_histo_chk #(
  parameter int BIN_AW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rd_valid,
  input logic [BIN_AW-1:0] rd_bin,
  input logic              cfg_we,
  input logic [5:0]        src_a,
  input logic [5:0]        src_b,
  input logic              clr_req,
  input logic              rd_req
);
  localparam int NBINS = 1 << BIN_AW;
  logic [BIN_AW+1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= busy ? run_len + 1'b1 : '0;
  end

  a_r5_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == (BIN_AW+2)'(NBINS));

  a_r5_req_starts: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_req || rd_req) && !busy) |=> busy);

  a_r6_first_bin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> rd_bin == '0);

  a_r6_bin_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid)) |-> rd_bin == $past(rd_bin) + 1'b1);

  a_r6_valid_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(busy));

  a_r9_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(src_a) && $stable(src_b)));
endmodule

bind tdiff_histo tdiff_histo_chk #(.BIN_AW(BIN_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_valid(rd_valid), .rd_bin(rd_bin),
  .cfg_we(cfg_we), .src_a(src_a), .src_b(src_b), .clr_req(clr_req), .rd_req(rd_req)
);

// File: tb/tdiff_histo_tb_top.sv
module tdiff_histo_tb_top;
  localparam int AW = 10;
  localparam int NB = 1 << AW;
  localparam int CW = 4;
  localparam int NV = 10;
  // vector table: A code, B code, gap tA-tB, expected bin (-1 = no count)
  // R1 codes from every group plus an unused one; R3 edges at +/-511 and +/-512; R4 gap 0
  localparam int VA  [NV] = '{0,  2, 24,   28,   48,  41,   35, 36,  55, 23};
  localparam int VB  [NV] = '{1,  3, 33,   40,   63,  56,   27,  0,  32, 31};
  localparam int VD  [NV] = '{5, -7,  0,  511, -511, 512, -512,  3, 100, -1};
  localparam int VE  [NV] = '{517, 505, 512, 1023, 1, -1, -1, -1, 612, 511};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [53:0] bus;
  logic cfg_we, cfg_ch, clr_req, rd_req;
  logic [5:0] cfg_code, src_a, src_b;
  logic busy, rd_valid;
  logic [AW-1:0] rd_bin;
  logic [CW-1:0] rd_count;

  tdiff_histo #(.BIN_AW(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .trig_in(bus[23:0]), .sync_in(bus[27:24]), .dbg_in(bus[31:28]), .aux_in(bus[35:32]),
    .and_in(bus[37:36]), .mult_in(bus[45:38]), .or_in(bus[53:46]),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_code(cfg_code), .src_a(src_a), .src_b(src_b),
    .clr_req(clr_req), .rd_req(rd_req), .busy(busy), .rd_valid(rd_valid),
    .rd_bin(rd_bin), .rd_count(rd_count)
  );

  int checks = 0;
  int errors = 0;
  int got, order_err, nbusy;
  logic [CW-1:0] hist [NB];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int code, input logic v);
    if (code < 36) bus[code] = v;
    else if (code == 40 || code == 41) bus[code-4] = v;
    else if (code >= 48 && code < 64) bus[code-10] = v;
  endtask

  task automatic fire(input int ca, input int cb, input int gap);
    int ta, tb;
    ta = (gap >= 0) ? gap : 0;
    tb = (gap >= 0) ? 0 : -gap;
    for (int k = 0; k <= ta + tb + 3; k++) begin
      @(negedge clk);
      drive(ca, (k >= ta && k < ta + 2));
      drive(cb, (k >= tb && k < tb + 2));
    end
    @(negedge clk);
    drive(ca, 1'b0);
    drive(cb, 1'b0);
    repeat (8) @(negedge clk);
  endtask

  task automatic set_src(input logic ch, input int code);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = ch; cfg_code = 6'(code);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
    nbusy = 0;
    while (busy && nbusy < 5000) begin
      nbusy++;
      @(negedge clk);
    end
  endtask

  task automatic do_read();
    int guard;
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    got = 0; order_err = 0; guard = 0;
    while (got < NB && guard < 3000) begin
      if (rd_valid) begin
        if (int'(rd_bin) != got) order_err++;
        hist[rd_bin] = rd_count;
        got++;
      end
      guard++;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic int total();
    int t = 0;
    for (int i = 0; i < NB; i++) t += int'(hist[i]);
    return t;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bus = '0; cfg_we = 1'b0; cfg_ch = 1'b0; cfg_code = '0;
    clr_req = 1'b0; rd_req = 1'b0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
    check(rd_valid == 1'b0, "R10 rd_valid after reset", int'(rd_valid), 0);
    check(src_a == 6'd0, "R10 src_a after reset", int'(src_a), 0);
    check(src_b == 6'd0, "R10 src_b after reset", int'(src_b), 0);

    set_src(1'b0, 17);
    set_src(1'b1, 45);
    check(src_a == 6'd17, "R9 src_a readback", int'(src_a), 17);
    check(src_b == 6'd45, "R9 src_b readback", int'(src_b), 45);

    do_clear();
    check(nbusy == NB, "R5 clear busy length", nbusy, NB);
    do_read();
    check(got == NB && order_err == 0, "R6 readout count/order", got - order_err, NB);
    check(total() == 0, "R5 all bins zero after clear", total(), 0);

    for (int i = 0; i < NV; i++) begin
      set_src(1'b0, VA[i]);
      set_src(1'b1, VB[i]);
      do_clear();
      fire(VA[i], VB[i], VD[i]);
      do_read();
      check(got == NB && order_err == 0, $sformatf("R6 readout vector %0d", i), got - order_err, NB);
      check(total() == ((VE[i] >= 0) ? 1 : 0),
            $sformatf("R1 R2 R3 R4 total vector %0d", i), total(), (VE[i] >= 0) ? 1 : 0);
      if (VE[i] >= 0)
        check(hist[VE[i]] == CW'(1), $sformatf("R2 R4 bin %0d vector %0d", VE[i], i),
              int'(hist[VE[i]]), 1);
    end

    // R7: pair completes while clear runs
    set_src(1'b0, 0);
    set_src(1'b1, 1);
    do_clear();
    fork
      do_clear();
      begin repeat (100) @(negedge clk); fire(0, 1, 4); end
    join
    do_read();
    check(total() == 0, "R7 pair during clear discarded", total(), 0);

    // R7: pair completes while readout runs
    repeat (600) @(negedge clk);
    fork
      do_read();
      begin repeat (100) @(negedge clk); fire(0, 1, 6); end
    join
    repeat (600) @(negedge clk);
    do_read();
    check(total() == 0, "R7 pair during readout discarded", total(), 0);

    // R8: saturation of a narrow counter
    do_clear();
    for (int n = 0; n < 20; n++) fire(0, 1, 3);
    do_read();
    check(hist[515] == {CW{1'b1}}, "R8 saturated bin 515", int'(hist[515]), (1 << CW) - 1);
    check(total() == (1 << CW) - 1, "R8 only bin 515 counted", total(), (1 << CW) - 1);

    // R2: negative gaps accumulate in one bin
    repeat (600) @(negedge clk);
    do_clear();
    for (int n = 0; n < 3; n++) begin
      fire(0, 1, -5);
      repeat (600) @(negedge clk);
    end
    do_read();
    check(hist[507] == CW'(3), "R2 accumulated bin 507", int'(hist[507]), 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule